// File: doc/BRIEF.md
# Receive Pad and Check-Sequence Stripper

This block sits in an Ethernet receive path, between the byte-wide deserialiser and the receive FIFO. It watches every frame as it goes by. When stripping is enabled and the frame's length/type field holds an IEEE 802.3 length below the 46-byte minimum payload, it forwards only the 14-byte header and the declared data bytes. It drops the trailing pad bytes and the 4-byte frame check sequence, which would no longer match the shortened frame. The FIFO therefore stores only useful bytes. Every other frame is forwarded as received, byte for byte: long 802.3 frames, Ethernet II frames whose field holds a type, and all frames while stripping is off.

The input and the output are plain byte streams, each with a valid and a last marker, and there is no backpressure. Every forwarded byte leaves exactly one clock after it arrives. The output carries one extra flag. It marks the final byte of a frame that ended too early: either a runt that ended inside the header, or a short frame that ended before its declared data was complete. Such frames are forwarded as received. The enable input is taken into an internal register only while the receive-on control is low, so it cannot change the treatment of a frame in flight.

Top module: `rx_pad_strip`

## Requirements
- R1: After reset, out_valid and out_err are 0 and stripping is disabled. It stays disabled until strip_en is high during a cycle in which rx_on is low.
- R2: The internal enable copies strip_en only in cycles where rx_on is 0. A change of strip_en while rx_on is 1 has no effect on the frames that follow.
- R3: Every forwarded byte appears on out_data with out_valid exactly one clock after the cycle in which it was presented, and in the same order.
- R4: The length/type field is read big-endian: byte index 12 (counting from 0) is the high byte and byte 13 is the low byte. When stripping is enabled and this value L is 0 to 45, only bytes 0 to 13+L are forwarded. out_last is set on byte 13+L with out_err 0, and all later bytes of the frame, FCS included, are dropped.
- R5: With stripping enabled, a frame whose field is an 802.3 length from 46 to 1500 is forwarded unmodified, with every byte including the FCS.
- R6: With stripping enabled, a field from 1501 up to 0x05FF, or any Ethernet type of 0x0600 or more, is never stripped, and the frame is forwarded unmodified.
- R7: With stripping disabled, every frame is forwarded unmodified, whatever its length field holds.
- R8: A frame with fewer than 14 bytes is forwarded as received, with out_err set together with out_last on its final byte. This holds whether stripping is enabled or not.
- R9: A frame selected for stripping that ends before byte 13+L is forwarded as received, with out_err set together with out_last on its final byte.
- R10: out_err is 1 only on a byte that also carries out_last and out_valid. Complete frames never raise it.
- R11: Frames presented back to back, with no idle cycle between them, are each handled on their own. Byte counting restarts after every input last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_on | input | 1 | Receive-on control; while high, the enable input is ignored |
| strip_en | input | 1 | Requested pad stripping enable |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the final byte of its frame |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte is the final forwarded byte of its frame |
| out_err | output | 1 | Frame ended before its header or its declared data was complete |

## Verification
A wrong byte position or a corrupted length capture shows up on the same frame. The final kept byte moves away from index 13+L, or out_last appears at a position the length field does not predict. A stale stripping decision or enable shows up on the next frame, which is cut when it should be whole or kept whole when it should be cut. Both are visible in the output byte count one clock after the byte concerned. A counter that does not restart after a last marker misplaces the length field of the next back-to-back frame, and the error shows within that frame.

// File: rtl/rx_pad_strip_pkg.sv
package rx_pad_strip_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic              vld;
    logic [BYTE_W-1:0] data;
    logic              last;
    logic              err;
  } byte_beat_t;

  // A length field below the minimum payload marks a frame to be stripped.
  function automatic logic f_is_short(input logic [2*BYTE_W-1:0] lf,
                                      input int unsigned min_data);
    return 32'(lf) < min_data;
  endfunction

  // Index of the last byte kept in a stripped frame: header plus declared data, minus one.
  function automatic int unsigned f_last_keep(input int unsigned hdr_bytes,
                                              input logic [2*BYTE_W-1:0] lf);
    return hdr_bytes - 1 + 32'(lf);
  endfunction

endpackage

// File: rtl/rx_pad_strip_cfg.sv
module rx_pad_strip_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_on,
  input  logic strip_en,
  output logic en_q
);
  // The enable register loads only while reception is off.
  always_ff @(posedge clk) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (!rx_on) en_q <= strip_en;
  end
endmodule

// File: rtl/rx_pad_strip_pos.sv
module rx_pad_strip_pos
  import rx_pad_strip_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned HDR_BYTES = 14,
  parameter int unsigned MIN_DATA  = 46
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_q,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic [CNT_W-1:0]  idx,
  output logic              cur_strip,
  output logic [CNT_W-1:0]  cur_end
);
  localparam logic [CNT_W-1:0] LEN_HI_IDX = CNT_W'(HDR_BYTES - 2);
  localparam logic [CNT_W-1:0] LEN_LO_IDX = CNT_W'(HDR_BYTES - 1);
  localparam logic [CNT_W-1:0] IDX_MAX    = {CNT_W{1'b1}};

  logic [BYTE_W-1:0]   hi_q;
  logic                strip_r;
  logic [CNT_W-1:0]    end_r;
  logic [2*BYTE_W-1:0] len_now;
  logic                short_now;
  logic [CNT_W-1:0]    end_now;
  logic                at_lo;

  assign len_now   = {hi_q, in_data};
  assign short_now = en_q && f_is_short(len_now, MIN_DATA);
  assign end_now   = CNT_W'(f_last_keep(HDR_BYTES, len_now));
  assign at_lo     = (idx == LEN_LO_IDX);

  // On the low length byte itself the decision is taken from the live byte.
  assign cur_strip = at_lo ? short_now : strip_r;
  assign cur_end   = at_lo ? end_now   : end_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx     <= '0;
      hi_q    <= '0;
      strip_r <= 1'b0;
      end_r   <= '0;
    end else if (in_valid) begin
      if (in_last)               idx <= '0;
      else if (idx != IDX_MAX)   idx <= idx + 1'b1;
      if (idx == LEN_HI_IDX)     hi_q <= in_data;
      if (in_last) begin
        strip_r <= 1'b0;
      end else if (at_lo) begin
        strip_r <= short_now;
        end_r   <= end_now;
      end
    end
  end
endmodule

// File: rtl/rx_pad_strip_sel.sv
module rx_pad_strip_sel
  import rx_pad_strip_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned HDR_BYTES = 14
) (
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  input  logic [CNT_W-1:0]  idx,
  input  logic              cur_strip,
  input  logic [CNT_W-1:0]  cur_end,
  output byte_beat_t        beat,
  output logic              drop_byte,
  output logic              final_byte
);
  localparam logic [CNT_W-1:0] LEN_LO_IDX = CNT_W'(HDR_BYTES - 1);

  logic in_hdr;
  assign in_hdr = (idx < LEN_LO_IDX);

  always_comb begin
    beat.vld   = in_valid;
    beat.data  = in_data;
    beat.last  = in_last;
    beat.err   = 1'b0;
    drop_byte  = 1'b0;
    final_byte = 1'b0;
    if (in_hdr) begin
      // A last marker inside the header: runt frame.
      beat.err = in_last;
    end else if (cur_strip) begin
      if (idx == cur_end) begin
        beat.last  = 1'b1;
        final_byte = in_valid;
      end else if (idx > cur_end) begin
        beat.vld  = 1'b0;
        beat.last = 1'b0;
        drop_byte = in_valid;
      end else begin
        // Ended before the declared data was complete.
        beat.err = in_last;
      end
    end
  end
endmodule

// File: rtl/rx_pad_strip_oreg.sv
module rx_pad_strip_oreg
  import rx_pad_strip_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  byte_beat_t beat,
  output byte_beat_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q.vld  <= beat.vld;
      q.data <= beat.data;
      q.last <= beat.vld & beat.last;
      q.err  <= beat.vld & beat.err;
    end
  end
endmodule

// File: rtl/rx_pad_strip.sv
module rx_pad_strip
  import rx_pad_strip_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned HDR_BYTES = 14,
  parameter int unsigned MIN_DATA  = 46
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_on,
  input  logic       strip_en,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       out_err
);
  logic             en_q;
  logic [CNT_W-1:0] idx;
  logic             cur_strip;
  logic [CNT_W-1:0] cur_end;
  logic             drop_byte;
  logic             final_byte;
  byte_beat_t       beat;
  byte_beat_t       q;

  rx_pad_strip_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .rx_on(rx_on), .strip_en(strip_en), .en_q(en_q)
  );

  rx_pad_strip_pos #(.CNT_W(CNT_W), .HDR_BYTES(HDR_BYTES), .MIN_DATA(MIN_DATA)) u_pos (
    .clk(clk), .rst_n(rst_n), .en_q(en_q),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .idx(idx), .cur_strip(cur_strip), .cur_end(cur_end)
  );

  rx_pad_strip_sel #(.CNT_W(CNT_W), .HDR_BYTES(HDR_BYTES)) u_sel (
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .idx(idx), .cur_strip(cur_strip), .cur_end(cur_end),
    .beat(beat), .drop_byte(drop_byte), .final_byte(final_byte)
  );

  rx_pad_strip_oreg u_oreg (
    .clk(clk), .rst_n(rst_n), .beat(beat), .q(q)
  );

  assign out_valid = q.vld;
  assign out_data  = q.data;
  assign out_last  = q.last;
  assign out_err   = q.err;
endmodule

// File: rtl/rx_pad_strip_chk.sv
module rx_pad_strip_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_on,
  input logic en_q,
  input logic in_valid,
  input logic cur_strip,
  input logic drop_byte,
  input logic final_byte,
  input logic out_valid,
  input logic out_last,
  input logic out_err
);
  p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_on |=> $stable(en_q));

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !drop_byte) |=> out_valid);

  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || drop_byte) |=> !out_valid);

  p_drop_only_strip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_byte |-> (in_valid && cur_strip));

  p_final_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    final_byte |=> (out_valid && out_last && !out_err));

  p_no_strip_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && $past(!en_q)) |-> !final_byte);

  p_err_with_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_valid && out_last));
endmodule

bind rx_pad_strip rx_pad_strip_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_on(rx_on), .en_q(en_q),
  .in_valid(in_valid), .cur_strip(cur_strip), .drop_byte(drop_byte),
  .final_byte(final_byte), .out_valid(out_valid), .out_last(out_last),
  .out_err(out_err)
);

// File: tb/rx_pad_strip_bench.sv
module rx_pad_strip_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  localparam int MAXF = 32;

  // Vector table: length field, total bytes, enable, requirement tag.
  localparam logic [15:0] T_LEN [NV] = '{16'd5, 16'd0, 16'd45, 16'd46, 16'd1500, 16'h05FF,
                                         16'h0800, 16'd10, 16'd30, 16'd3, 16'd3, 16'd20};
  localparam int T_TOT [NV] = '{64, 64, 64, 64, 64, 64, 64, 64, 20, 10, 10, 34};
  localparam bit T_EN  [NV] = '{1, 1, 1, 1, 1, 1, 1, 0, 1, 1, 0, 1};
  localparam string T_REQ [NV] = '{"R4", "R4", "R4", "R5", "R5", "R6", "R6", "R7",
                                   "R9", "R8", "R8", "R4"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_on = 1'b0;
  logic strip_en = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_last = 1'b0;
  logic out_valid, out_last, out_err;
  logic [7:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  bit eff_en = 1'b0;
  int n_sent = 0;
  int nf = 0;
  int pos = 0;
  logic [15:0] exp_len [MAXF];
  int    exp_cnt [MAXF];
  bit    exp_err [MAXF];
  string exp_req [MAXF];
  int    got_cnt [MAXF];
  bit    got_err [MAXF];
  int    mism    [MAXF];
  int    errbad  [MAXF];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_pad_strip u_rx_pad_strip (
    .clk(clk), .rst_n(rst_n), .rx_on(rx_on), .strip_en(strip_en),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_err(out_err)
  );

  function automatic logic [7:0] gen_byte(input int i, input logic [15:0] lf);
    if (i == 12) return lf[15:8];
    if (i == 13) return lf[7:0];
    return 8'((i * 7 + 3) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: samples at the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && out_valid && nf < MAXF) begin
      if (out_data != gen_byte(pos, exp_len[nf])) mism[nf]++;
      if (out_err && !out_last) errbad[nf]++;
      pos++;
      if (out_last) begin
        got_cnt[nf] = pos;
        got_err[nf] = out_err;
        nf++;
        pos = 0;
      end
    end
  end

  task automatic set_enable(input bit v);
    @(negedge clk); rx_on = 1'b0; strip_en = v;
    @(negedge clk); rx_on = 1'b1;
    eff_en = v;
  endtask

  task automatic record(input logic [15:0] lf, input int tot, input string req);
    bit cut;
    cut = eff_en && (lf < 16'd46) && (tot >= 14);
    exp_len[n_sent] = lf;
    exp_cnt[n_sent] = (cut && tot > 14 + int'(lf)) ? 14 + int'(lf) : tot;
    exp_err[n_sent] = (tot < 14) || (cut && tot < 14 + int'(lf));
    exp_req[n_sent] = req;
    got_cnt[n_sent] = -1;
    got_err[n_sent] = 1'b0;
    mism[n_sent] = 0;
    errbad[n_sent] = 0;
    n_sent++;
  endtask

  task automatic send_frame(input logic [15:0] lf, input int tot, input string req,
                            input bit gap);
    record(lf, tot, req);
    for (int i = 0; i < tot; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = gen_byte(i, lf);
      in_last  = (i == tot - 1);
    end
    if (gap) begin
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk(out_valid == 1'b0 && out_err == 1'b0, "R1 reset outputs", int'(out_valid), 0);
    rx_on = 1'b1; strip_en = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    // R1: reset left stripping off, rx_on held high, so a short frame stays whole
    eff_en = 1'b0;
    send_frame(16'd5, 64, "R1", 1'b1);

    for (int v = 0; v < NV; v++) begin
      if (T_EN[v] != eff_en) set_enable(T_EN[v]);
      send_frame(T_LEN[v], T_TOT[v], T_REQ[v], 1'b1);
    end

    // R11: back-to-back frames with stripping on
    set_enable(1'b1);
    send_frame(16'd2, 64, "R11", 1'b0);
    send_frame(16'd0, 20, "R11", 1'b0);
    send_frame(16'h0800, 30, "R11", 1'b1);

    // R2: strip_en toggled while rx_on high has no effect
    set_enable(1'b0);
    @(negedge clk); strip_en = 1'b1;
    send_frame(16'd8, 64, "R2", 1'b1);
    set_enable(1'b1);
    @(negedge clk); strip_en = 1'b0;
    send_frame(16'd8, 64, "R2", 1'b1);

    // R3/R8: one-byte runt, exact one-clock latency
    record(16'h0000, 1, "R8");
    exp_len[n_sent-1] = 16'h0000;
    @(negedge clk);
    in_valid = 1'b1; in_data = gen_byte(0, 16'h0000); in_last = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    chk(out_valid && out_data == gen_byte(0, 16'h0000) && out_last && out_err,
        "R3 latency", int'(out_data), int'(gen_byte(0, 16'h0000)));

    repeat (5) @(negedge clk);
    chk(nf == n_sent, "R11 frame count", nf, n_sent);
    for (int f = 0; f < n_sent; f++) begin
      chk(got_cnt[f] == exp_cnt[f], {exp_req[f], " byte count"}, got_cnt[f], exp_cnt[f]);
      chk(got_err[f] == exp_err[f] && errbad[f] == 0, {exp_req[f], " R10 error flag"},
          int'(got_err[f]), int'(exp_err[f]));
      chk(mism[f] == 0, {exp_req[f], " R3 data"}, mism[f], 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule